// File: doc/BRIEF.md
# Next-PC and Instruction Kill Control

This block is the purely combinational steering logic for the front end of a five-stage in-order pipeline that has no delay slots. Conditional branches are resolved in the execute stage. Unconditional jumps, both absolute and register-indirect, are recognised in the decode stage. From the opcodes sitting in decode and execute, the zero flag of the execute operand and the interlock stall, it chooses the source of the next fetch address. It also decides whether the decode and execute instruction registers take their normal input or an all-zero nop.

A jump redirects fetch from decode, so it squashes only the one instruction fetched behind it and leaves a single bubble. A taken branch redirects fetch from execute. It squashes both younger instructions, the one in decode and the one being fetched, and it overrides any jump that happens to be in decode in the same cycle, because the older instruction has priority. The block also tells the PC register when to hold: during a stall, unless a taken branch is forcing a redirect. Target arithmetic and the datapath muxes themselves live elsewhere.

Top module: `npc_kill_ctl`

## Requirements
- R1: Opcodes are 6-bit values with these codes: nop 0, ALU 1, BEQZ 2, BNEZ 3, J 4, JAL 5, JR 6, JALR 7. Every other code is a non-control instruction. A branch in execute is taken when the execute opcode is BEQZ with zero set, or BNEZ with zero clear.
- R2: When a branch in execute is taken, `pc_src` is 3 (branch target), whatever opcode is in decode.
- R3: With no taken branch, `pc_src` is 1 (absolute jump) for J or JAL in decode, and 2 (register-indirect) for JR or JALR in decode.
- R4: In every other case `pc_src` is 0 (sequential, PC plus one instruction).
- R5: `dec_ir_nop` is 1 (load the nop, code 0) when a taken branch is in execute or a jump (J, JAL, JR, JALR) is in decode. Otherwise it is 0 (load the fetched instruction).
- R6: `exe_ir_nop` is 1 (load the nop) when a taken branch is in execute. Otherwise it equals `stall`: the nop when stalled, the decode IR when not.
- R7: `pc_hold` is 1 exactly when `stall` is 1 and no taken branch is in execute.
- R8: A not-taken branch in execute (BEQZ with zero clear, BNEZ with zero set) has no effect: all four outputs equal those produced with an ALU opcode in execute.
- R9: A jump kills one younger instruction: only `dec_ir_nop` is set, and `exe_ir_nop` stays 0 when there is no stall. A taken branch kills two: both `dec_ir_nop` and `exe_ir_nop` are set, even if `stall` is asserted at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_op | input | 6 | Opcode of the instruction in decode |
| exe_op | input | 6 | Opcode of the instruction in execute |
| exe_zero | input | 1 | Operand of the execute instruction equals zero |
| stall | input | 1 | Interlock stall request |
| pc_src | output | 2 | Next-PC select: 0 sequential, 1 absolute, 2 indirect, 3 branch |
| dec_ir_nop | output | 1 | Decode IR loads the nop instead of the fetched word |
| exe_ir_nop | output | 1 | Execute IR loads the nop instead of the decode IR |
| pc_hold | output | 1 | PC register keeps its value |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench applies inputs just after a falling clock edge and compares all four outputs one nanosecond later, well before the next rising edge. Expected values come from a bench function written from the requirements. The random sweep is biased toward the control opcodes. Directed cases cover the corner combinations: both branch senses under both zero values, and a jump meeting a taken branch with and without stall.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W = 6;
    localparam int SEL_W = 2;

    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_NOP  = opc_t'(0);
    localparam opc_t OPC_ALU  = opc_t'(1);
    localparam opc_t OPC_BEQZ = opc_t'(2);
    localparam opc_t OPC_BNEZ = opc_t'(3);
    localparam opc_t OPC_J    = opc_t'(4);
    localparam opc_t OPC_JAL  = opc_t'(5);
    localparam opc_t OPC_JR   = opc_t'(6);
    localparam opc_t OPC_JALR = opc_t'(7);

    typedef enum logic [SEL_W-1:0] {
        PCS_SEQ = 2'd0,
        PCS_ABS = 2'd1,
        PCS_IND = 2'd2,
        PCS_BR  = 2'd3
    } pc_src_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'd0,
        JMP_ABS  = 2'd1,
        JMP_IND  = 2'd2
    } jmp_kind_e;

    typedef struct packed {
        pc_src_e src;
        logic    dec_nop;
        logic    exe_nop;
        logic    hold;
    } steer_t;

    function automatic jmp_kind_e classify_jump(opc_t op);
        if (op == OPC_J || op == OPC_JAL)
            return JMP_ABS;
        else if (op == OPC_JR || op == OPC_JALR)
            return JMP_IND;
        else
            return JMP_NONE;
    endfunction

    function automatic logic branch_resolves_taken(opc_t op, logic zero);
        return ((op == OPC_BEQZ) && zero) || ((op == OPC_BNEZ) && !zero);
    endfunction

endpackage

// File: rtl/npc_branch_eval.sv
module npc_branch_eval
    import npc_pkg::*;
(
    input  opc_t exe_op,
    input  logic exe_zero,
    output logic taken
);
    // R1: branch outcome from execute opcode and zero flag
    always_comb taken = branch_resolves_taken(exe_op, exe_zero);
endmodule

// File: rtl/npc_jump_decode.sv
module npc_jump_decode
    import npc_pkg::*;
(
    input  opc_t      dec_op,
    output jmp_kind_e kind
);
    always_comb kind = classify_jump(dec_op);
endmodule

// File: rtl/npc_pc_steer.sv
module npc_pc_steer
    import npc_pkg::*;
(
    input  logic      br_taken,
    input  jmp_kind_e jmp,
    input  logic      stall,
    output pc_src_e   src,
    output logic      hold
);
    // Older execute-stage branch outranks decode-stage jump (R2, R3, R4)
    always_comb begin
        if (br_taken)
            src = PCS_BR;
        else begin
            unique case (jmp)
                JMP_ABS: src = PCS_ABS;
                JMP_IND: src = PCS_IND;
                default: src = PCS_SEQ;
            endcase
        end
        hold = stall && !br_taken; // R7
    end
endmodule

// File: rtl/npc_ir_kill.sv
module npc_ir_kill
    import npc_pkg::*;
(
    input  logic      br_taken,
    input  jmp_kind_e jmp,
    input  logic      stall,
    output logic      dec_nop,
    output logic      exe_nop
);
    // R5, R6, R9: squash count depends on the stage that redirects
    always_comb begin
        dec_nop = br_taken || (jmp != JMP_NONE);
        exe_nop = br_taken ? 1'b1 : stall;
    end
endmodule

// File: rtl/npc_kill_ctl.sv
module npc_kill_ctl
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] dec_op,
    input  logic [OPC_W-1:0] exe_op,
    input  logic             exe_zero,
    input  logic             stall,
    output logic [SEL_W-1:0] pc_src,
    output logic             dec_ir_nop,
    output logic             exe_ir_nop,
    output logic             pc_hold
);
    logic      br_taken;
    jmp_kind_e jmp;
    steer_t    st;

    npc_branch_eval u_br (
        .exe_op   (exe_op),
        .exe_zero (exe_zero),
        .taken    (br_taken)
    );

    npc_jump_decode u_jd (
        .dec_op (dec_op),
        .kind   (jmp)
    );

    npc_pc_steer u_pc (
        .br_taken (br_taken),
        .jmp      (jmp),
        .stall    (stall),
        .src      (st.src),
        .hold     (st.hold)
    );

    npc_ir_kill u_ir (
        .br_taken (br_taken),
        .jmp      (jmp),
        .stall    (stall),
        .dec_nop  (st.dec_nop),
        .exe_nop  (st.exe_nop)
    );

    assign pc_src     = st.src;
    assign dec_ir_nop = st.dec_nop;
    assign exe_ir_nop = st.exe_nop;
    assign pc_hold    = st.hold;
endmodule

// File: rtl/npc_kill_ctl_chk.sv
module npc_kill_ctl_chk
    import npc_pkg::*;
(
    input logic [OPC_W-1:0] dec_op,
    input logic [OPC_W-1:0] exe_op,
    input logic             exe_zero,
    input logic             stall,
    input logic [SEL_W-1:0] pc_src,
    input logic             dec_ir_nop,
    input logic             exe_ir_nop,
    input logic             pc_hold
);
    always_comb begin
        if (!$isunknown({dec_op, exe_op, exe_zero, stall, pc_src,
                         dec_ir_nop, exe_ir_nop, pc_hold})) begin
            // R2: a branch-target select always squashes both younger slots
            p_branch_kills_two_r2: assert (pc_src != 2'd3 || (dec_ir_nop && exe_ir_nop))
                else $error("branch select without double kill");
            // R5: any redirect away from sequential fetch squashes decode
            p_redirect_kills_decode_r5: assert (pc_src == 2'd0 || dec_ir_nop)
                else $error("redirect without decode kill");
            // R7: hold never coincides with a branch redirect
            p_hold_not_branch_r7: assert (!(pc_hold && pc_src == 2'd3))
                else $error("pc held during branch redirect");
            // R6: an unstalled, non-branch cycle passes decode IR forward
            p_exe_pass_r6: assert (stall || pc_src == 2'd3 || !exe_ir_nop)
                else $error("execute killed without cause");
            // R3: a decode-stage jump target select implies stall-free execute kill only on stall
            p_jump_one_kill_r3: assert (!(pc_src inside {2'd1, 2'd2}) || exe_ir_nop == stall)
                else $error("jump killed execute slot");
            // R7: hold appears only with a stall request
            p_hold_needs_stall_r7: assert (!pc_hold || stall)
                else $error("hold without stall");
        end
    end
endmodule

bind npc_kill_ctl npc_kill_ctl_chk u_chk (
    .dec_op     (dec_op),
    .exe_op     (exe_op),
    .exe_zero   (exe_zero),
    .stall      (stall),
    .pc_src     (pc_src),
    .dec_ir_nop (dec_ir_nop),
    .exe_ir_nop (exe_ir_nop),
    .pc_hold    (pc_hold)
);

// File: tb/npc_kill_ctl_tb.sv
module npc_kill_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] dec_op = '0;
    logic [5:0] exe_op = '0;
    logic       exe_zero = 1'b0;
    logic       stall = 1'b0;
    logic [1:0] pc_src;
    logic       dec_ir_nop, exe_ir_nop, pc_hold;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    npc_kill_ctl dut_i (
        .dec_op(dec_op), .exe_op(exe_op), .exe_zero(exe_zero), .stall(stall),
        .pc_src(pc_src), .dec_ir_nop(dec_ir_nop), .exe_ir_nop(exe_ir_nop),
        .pc_hold(pc_hold)
    );

    // Expected outputs packed as {pc_src[1:0], dec_nop, exe_nop, hold}
    function automatic logic [4:0] model(logic [5:0] d, logic [5:0] e, logic z, logic s);
        logic tk;
        logic [1:0] src;
        logic dn, en, h;
        tk = (e == 6'd2 && z) || (e == 6'd3 && !z);
        if (tk) src = 2'd3;
        else if (d == 6'd4 || d == 6'd5) src = 2'd1;
        else if (d == 6'd6 || d == 6'd7) src = 2'd2;
        else src = 2'd0;
        dn = tk || (d >= 6'd4 && d <= 6'd7);
        en = tk ? 1'b1 : s;
        h  = s && !tk;
        return {src, dn, en, h};
    endfunction

    task automatic apply_check(input logic [5:0] d, input logic [5:0] e,
                               input logic z, input logic s, input string req);
        logic [4:0] exp, act;
        @(negedge clk);
        dec_op = d; exe_op = e; exe_zero = z; stall = s;
        #1;
        exp = model(d, e, z, s);
        act = {pc_src, dec_ir_nop, exe_ir_nop, pc_hold};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s dec=%0d exe=%0d z=%0b s=%0b actual=%b expected=%b",
                     req, d, e, z, s, act, exp);
        end
    endtask

    // R8: not-taken branch equals an ALU op in execute
    task automatic check_not_taken(input logic [5:0] d, input logic [5:0] e,
                                   input logic z, input logic s);
        logic [4:0] a1, a2;
        @(negedge clk);
        dec_op = d; exe_op = e; exe_zero = z; stall = s;
        #1 a1 = {pc_src, dec_ir_nop, exe_ir_nop, pc_hold};
        exe_op = 6'd1;
        #1 a2 = {pc_src, dec_ir_nop, exe_ir_nop, pc_hold};
        n_checks++;
        if (a1 !== a2) begin
            n_fails++;
            $display("FAIL R8 dec=%0d exe=%0d z=%0b actual=%b expected=%b", d, e, z, a1, a2);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: nop in both stages gives sequential fetch, no kill
        apply_check(6'd0, 6'd0, 1'b0, 1'b0, "R4 reset-idle");
        // R1/R2: taken branches of both senses
        apply_check(6'd1, 6'd2, 1'b1, 1'b0, "R2 beqz taken");
        apply_check(6'd1, 6'd3, 1'b0, 1'b0, "R2 bnez taken");
        // R8: not-taken of both senses
        check_not_taken(6'd1, 6'd2, 1'b0, 1'b0);
        check_not_taken(6'd4, 6'd3, 1'b1, 1'b0);
        check_not_taken(6'd6, 6'd2, 1'b0, 1'b1);
        // R3: each jump kind
        apply_check(6'd4, 6'd1, 1'b0, 1'b0, "R3 j");
        apply_check(6'd5, 6'd0, 1'b1, 1'b0, "R3 jal");
        apply_check(6'd6, 6'd1, 1'b0, 1'b0, "R3 jr");
        apply_check(6'd7, 6'd9, 1'b0, 1'b0, "R3 jalr");
        // R9: jump meets taken branch, with and without stall
        apply_check(6'd4, 6'd2, 1'b1, 1'b0, "R9 branch over j");
        apply_check(6'd7, 6'd3, 1'b0, 1'b1, "R9 branch over jalr stalled");
        // R6/R7: stall behaviour
        apply_check(6'd1, 6'd1, 1'b0, 1'b1, "R6 stall alu");
        apply_check(6'd63, 6'd2, 1'b1, 1'b1, "R7 stall with taken");
        apply_check(6'd5, 6'd1, 1'b0, 1'b1, "R7 stall with jump");
        // R5/R4: high opcode codes are non-control
        apply_check(6'd8, 6'd63, 1'b1, 1'b0, "R5 non-control");
        // Random sweep biased toward control codes
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] d, e;
            d = ($urandom % 4 != 0) ? 6'($urandom % 8) : 6'($urandom);
            e = ($urandom % 4 != 0) ? 6'($urandom % 8) : 6'($urandom);
            apply_check(d, e, 1'($urandom), 1'($urandom), "R1-random");
        end
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule